// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the hardwired control unit of a small accumulator processor. It tracks which part of the instruction cycle the machine is in (fetch, indirect, execute or interrupt) with a 2-bit cycle code. A time-step counter tracks the position within that phase. From the two registers, the instruction's opcode and indirect bit, the zero flag and a gated interrupt request, it produces a one-hot control word. The word holds register loads, bus drive enables, memory read and write strobes, a PC increment and an ALU function select. An external datapath with registers PC, MAR, MDR, IR, AC, Y and Z carries out each step.

The control word is decoded from the registered phase and step. A datapath register loaded in one step is therefore seen by the decode in the next step. The indirect bit is sampled in fetch step 3, so the datapath must present the bit of the instruction entering IR (taken from the MDR side) during that step. The interrupt enable is held inside the sequencer. An enable-interrupts instruction sets it, and entry into the interrupt phase clears it.

Top module: `icc_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the cycle code at 00, the step counter at 1 and the interrupt enable at 0.
- R2: The cycle code is 00 in fetch, 01 in indirect, 10 in execute and 11 in interrupt. The step counter starts at 1 in each phase, counts up by one per clock, and returns to 1 when the phase ends.
- R3: Fetch takes three steps. Step 1 asserts bit 0 (MAR from PC). Step 2 asserts bit 3 (memory read into MDR) and bit 5 (PC increment). Step 3 asserts bit 6 (IR from MDR). The memory read never shares a step with the IR load, and it always follows a step in which bit 0 was set.
- R4: At the end of fetch, the phase goes to indirect when ind_i is 1 during fetch step 3, and to execute otherwise.
- R5: Indirect takes three steps: bit 1 (MAR from the IR address field), then bit 3 (memory read), then bit 7 (IR address field from MDR). The next phase is always execute.
- R6: Opcodes 0 (add), 1 (and) and 2 (load) execute in five steps: bit 1, bit 3, bit 11 (Y from MDR), bit 12 (Z from ALU), bit 13 (AC from Z). In step 4, bits 17:16 carry the ALU select: 00 add, 01 and, 10 pass Y. These bits are 00 at all other times.
- R7: Opcode 3 (store) executes in two steps. Step 1 asserts bits 1 and 10 (MDR from AC) together. Step 2 asserts bit 4 (memory write).
- R8: Opcodes 4 (jump), 5 (jump if zero), 6 (enable interrupts) and 7 (no operation) execute in one step. Jump asserts bit 14 (PC from IR address). Jump-if-zero asserts bit 14 only while zero_i is 1. Enable-interrupts asserts bit 15 and sets the enable. No-operation asserts nothing.
- R9: At the last execute step, the phase goes to interrupt when irq_i is 1 and the enable is set, and to fetch otherwise. Entering interrupt clears the enable. The clear wins over a set from an enable-interrupts instruction in the same step.
- R10: Interrupt takes three steps. Step 1 asserts bit 8 (MDR from PC). Step 2 asserts bit 2 (MAR from the save address) and bit 9 (PC from the handler address), while save_addr_o and isr_addr_o carry the two address parameters. Step 3 asserts bit 4 (memory write). The next phase is fetch. Both address ports are 0 in every other step.
- R11: Every control bit not named for the current phase and step is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Opcode field of the current instruction |
| ind_i | input | 1 | Indirect-address bit of the instruction |
| zero_i | input | 1 | Accumulator zero flag |
| irq_i | input | 1 | Interrupt request |
| ctrl_o | output | 18 | Control word (bit map in R3 to R10) |
| icc_o | output | 2 | Current cycle code |
| step_o | output | STEP_W | Current time step, starting at 1 |
| ie_o | output | 1 | Interrupt enable state |
| save_addr_o | output | AW | PC save address, driven in interrupt step 2 |
| isr_addr_o | output | AW | Handler start address, driven in interrupt step 2 |

## Verification
Setting the enable and clearing it can fall on the same clock edge. This happens when an enable-interrupts instruction executes while the enable is already on and irq_i is high at its single step. The bench provokes the collision with a directed pair of such instructions, and random instruction streams with a pending request reach it again. The reference model requires the phase to move to interrupt and the enable to read 0 after that edge. The model is compared with the outputs on every clock.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_IND   = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;

  localparam int OP_W = 3;
  localparam int CW   = 18;

  // control word bit map
  localparam int B_MAR_PC   = 0;
  localparam int B_MAR_IR   = 1;
  localparam int B_MAR_SAVE = 2;
  localparam int B_MEM_RD   = 3;
  localparam int B_MEM_WR   = 4;
  localparam int B_PC_INC   = 5;
  localparam int B_IR_LD    = 6;
  localparam int B_IR_ADDR  = 7;
  localparam int B_MDR_PC   = 8;
  localparam int B_PC_ISR   = 9;
  localparam int B_MDR_AC   = 10;
  localparam int B_Y_LD     = 11;
  localparam int B_Z_LD     = 12;
  localparam int B_AC_LD    = 13;
  localparam int B_PC_JMP   = 14;
  localparam int B_IE_SET   = 15;
  localparam int B_ALU_LO   = 16;
  localparam int B_ALU_HI   = 17;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_AND  = 2'b01;
  localparam logic [1:0] ALU_PASS = 2'b10;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_AND = 3'd1;
  localparam logic [OP_W-1:0] OP_LDA = 3'd2;
  localparam logic [OP_W-1:0] OP_STA = 3'd3;
  localparam logic [OP_W-1:0] OP_JMP = 3'd4;
  localparam logic [OP_W-1:0] OP_JZ  = 3'd5;
  localparam logic [OP_W-1:0] OP_EI  = 3'd6;
  localparam logic [OP_W-1:0] OP_NOP = 3'd7;

  localparam int FIXED_PHASE_LEN = 3;

  function automatic int exec_len(logic [OP_W-1:0] op);
    case (op)
      OP_ADD, OP_AND, OP_LDA: return 5;
      OP_STA:                 return 2;
      default:                return 1;
    endcase
  endfunction

endpackage

// File: rtl/icc_phase_ctrl.sv
module icc_phase_ctrl
  import icc_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     op_i,
  input  logic                ind_i,
  input  logic                irq_i,
  input  logic                ie_set_i,
  output phase_e              phase_o,
  output logic [STEP_W-1:0]   step_o,
  output logic                ie_o
);

  localparam logic [STEP_W-1:0] STEP_FIRST = STEP_W'(1);

  phase_e            phase_q, phase_nx;
  logic [STEP_W-1:0] step_q;
  logic              ie_q;
  logic              last;
  logic              enter_intr;

  always_comb begin
    case (phase_q)
      PH_EXEC: last = int'(step_q) >= exec_len(op_i);
      default: last = int'(step_q) >= FIXED_PHASE_LEN;
    endcase
  end

  assign enter_intr = (phase_q == PH_EXEC) && last && irq_i && ie_q;

  always_comb begin
    case (phase_q)
      PH_FETCH: phase_nx = ind_i ? PH_IND : PH_EXEC;
      PH_IND:   phase_nx = PH_EXEC;
      PH_EXEC:  phase_nx = enter_intr ? PH_INTR : PH_FETCH;
      default:  phase_nx = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      step_q  <= STEP_FIRST;
      ie_q    <= 1'b0;
    end else begin
      if (last) begin
        phase_q <= phase_nx;
        step_q  <= STEP_FIRST;
      end else begin
        step_q  <= step_q + STEP_FIRST;
      end
      if (enter_intr)    ie_q <= 1'b0;
      else if (ie_set_i) ie_q <= 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;
  assign ie_o    = ie_q;

  // R2: the step counter is never zero out of reset
  a_r2_step_nonzero: assert property (@(posedge clk) disable iff (rst)
    step_q != '0);

  // R5: indirect always hands over to execute
  a_r5_ind_to_exec: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IND && int'(step_q) == FIXED_PHASE_LEN) |=> (phase_q == PH_EXEC));

  // R9: a taken interrupt lands in the interrupt phase with the enable off
  a_r9_ie_cleared: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC && last && irq_i && ie_q) |=> (phase_q == PH_INTR && !ie_q));

  // R10: interrupt returns to fetch step 1
  a_r10_intr_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INTR && int'(step_q) == FIXED_PHASE_LEN)
      |=> (phase_q == PH_FETCH && step_q == STEP_FIRST));

endmodule

// File: rtl/icc_decode.sv
module icc_decode
  import icc_pkg::*;
#(
  parameter int              STEP_W    = 3,
  parameter int              AW        = 12,
  parameter logic [AW-1:0]   SAVE_ADDR = '0,
  parameter logic [AW-1:0]   ISR_ADDR  = '0
) (
  input  phase_e              phase_i,
  input  logic [STEP_W-1:0]   step_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic                zero_i,
  output logic [CW-1:0]       ctrl_o,
  output logic [AW-1:0]       save_addr_o,
  output logic [AW-1:0]       isr_addr_o
);

  logic [CW-1:0] w;
  logic [1:0]    alu;

  always_comb begin
    case (op_i)
      OP_AND:  alu = ALU_AND;
      OP_LDA:  alu = ALU_PASS;
      default: alu = ALU_ADD;
    endcase
  end

  always_comb begin
    w = '0;
    case (phase_i)
      PH_FETCH: begin
        case (int'(step_i))
          1: w[B_MAR_PC] = 1'b1;
          2: begin w[B_MEM_RD] = 1'b1; w[B_PC_INC] = 1'b1; end
          3: w[B_IR_LD] = 1'b1;
          default: ;
        endcase
      end
      PH_IND: begin
        case (int'(step_i))
          1: w[B_MAR_IR]  = 1'b1;
          2: w[B_MEM_RD]  = 1'b1;
          3: w[B_IR_ADDR] = 1'b1;
          default: ;
        endcase
      end
      PH_INTR: begin
        case (int'(step_i))
          1: w[B_MDR_PC] = 1'b1;
          2: begin w[B_MAR_SAVE] = 1'b1; w[B_PC_ISR] = 1'b1; end
          3: w[B_MEM_WR] = 1'b1;
          default: ;
        endcase
      end
      default: begin
        case (op_i)
          OP_ADD, OP_AND, OP_LDA: begin
            case (int'(step_i))
              1: w[B_MAR_IR] = 1'b1;
              2: w[B_MEM_RD] = 1'b1;
              3: w[B_Y_LD]   = 1'b1;
              4: begin w[B_Z_LD] = 1'b1; w[B_ALU_HI:B_ALU_LO] = alu; end
              5: w[B_AC_LD]  = 1'b1;
              default: ;
            endcase
          end
          OP_STA: begin
            case (int'(step_i))
              1: begin w[B_MAR_IR] = 1'b1; w[B_MDR_AC] = 1'b1; end
              2: w[B_MEM_WR] = 1'b1;
              default: ;
            endcase
          end
          OP_JMP:  if (int'(step_i) == 1) w[B_PC_JMP] = 1'b1;
          OP_JZ:   if (int'(step_i) == 1) w[B_PC_JMP] = zero_i;
          OP_EI:   if (int'(step_i) == 1) w[B_IE_SET] = 1'b1;
          default: ;
        endcase
      end
    endcase
  end

  assign ctrl_o      = w;
  assign save_addr_o = w[B_MAR_SAVE] ? SAVE_ADDR : '0;
  assign isr_addr_o  = w[B_PC_ISR]   ? ISR_ADDR  : '0;

  // R3: a memory read and the IR load never share a step
  always_comb begin
    a_r3_rd_not_with_ir: assert (!(w[B_MEM_RD] && w[B_IR_LD]));
  end

endmodule

// File: rtl/icc_sequencer.sv
module icc_sequencer
  import icc_pkg::*;
#(
  parameter int            STEP_W    = 3,
  parameter int            AW        = 12,
  parameter logic [AW-1:0] SAVE_ADDR = AW'('h010),
  parameter logic [AW-1:0] ISR_ADDR  = AW'('h100)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OP_W-1:0]      op_i,
  input  logic                 ind_i,
  input  logic                 zero_i,
  input  logic                 irq_i,
  output logic [CW-1:0]        ctrl_o,
  output logic [1:0]           icc_o,
  output logic [STEP_W-1:0]    step_o,
  output logic                 ie_o,
  output logic [AW-1:0]        save_addr_o,
  output logic [AW-1:0]        isr_addr_o
);

  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic [CW-1:0]     ctrl;

  icc_phase_ctrl #(.STEP_W(STEP_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .ind_i    (ind_i),
    .irq_i    (irq_i),
    .ie_set_i (ctrl[B_IE_SET]),
    .phase_o  (phase),
    .step_o   (step),
    .ie_o     (ie_o)
  );

  icc_decode #(
    .STEP_W    (STEP_W),
    .AW        (AW),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
  ) u_decode (
    .phase_i     (phase),
    .step_i      (step),
    .op_i        (op_i),
    .zero_i      (zero_i),
    .ctrl_o      (ctrl),
    .save_addr_o (save_addr_o),
    .isr_addr_o  (isr_addr_o)
  );

  assign ctrl_o = ctrl;
  assign icc_o  = phase;
  assign step_o = step;

  // R3: the fetch read always follows a MAR-from-PC step
  a_r3_rd_after_mar: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && ctrl[B_MEM_RD]) |-> $past(ctrl[B_MAR_PC]));

  // R11: read and write strobes are exclusive
  a_r11_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[B_MEM_RD] && ctrl[B_MEM_WR]));

endmodule

// File: tb/icc_sequencer_tb.sv
module icc_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_W     = 3;
  localparam int AW         = 12;
  localparam logic [AW-1:0] SAVE = 12'h010;
  localparam logic [AW-1:0] ISR  = 12'h100;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] op_i = '0;
  logic ind_i = 1'b0, zero_i = 1'b0, irq_i = 1'b0;
  logic [17:0] ctrl_o;
  logic [1:0] icc_o;
  logic [STEP_W-1:0] step_o;
  logic ie_o;
  logic [AW-1:0] save_addr_o, isr_addr_o;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int m_ph = 0, m_st = 1;
  bit m_ie = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icc_sequencer #(.STEP_W(STEP_W), .AW(AW), .SAVE_ADDR(SAVE), .ISR_ADDR(ISR)) u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .ind_i(ind_i), .zero_i(zero_i), .irq_i(irq_i),
    .ctrl_o(ctrl_o), .icc_o(icc_o), .step_o(step_o), .ie_o(ie_o),
    .save_addr_o(save_addr_o), .isr_addr_o(isr_addr_o)
  );

  function automatic int len_of(int ph, int op);
    if (ph != 2) return 3;
    if (op <= 2) return 5;
    if (op == 3) return 2;
    return 1;
  endfunction

  function automatic logic [17:0] ref_word(int ph, int st, int op, bit z);
    logic [17:0] w = '0;
    if (ph == 0) begin
      if (st == 1) w[0] = 1;
      if (st == 2) begin w[3] = 1; w[5] = 1; end
      if (st == 3) w[6] = 1;
    end else if (ph == 1) begin
      if (st == 1) w[1] = 1;
      if (st == 2) w[3] = 1;
      if (st == 3) w[7] = 1;
    end else if (ph == 3) begin
      if (st == 1) w[8] = 1;
      if (st == 2) begin w[2] = 1; w[9] = 1; end
      if (st == 3) w[4] = 1;
    end else if (op <= 2) begin
      if (st == 1) w[1] = 1;
      if (st == 2) w[3] = 1;
      if (st == 3) w[11] = 1;
      if (st == 4) begin w[12] = 1; w[17:16] = (op == 1) ? 2'b01 : (op == 2) ? 2'b10 : 2'b00; end
      if (st == 5) w[13] = 1;
    end else if (op == 3) begin
      if (st == 1) begin w[1] = 1; w[10] = 1; end
      if (st == 2) w[4] = 1;
    end else if (st == 1) begin
      if (op == 4) w[14] = 1;
      if (op == 5) w[14] = z;
      if (op == 6) w[15] = 1;
    end
    return w;
  endfunction

  function automatic string req_of(int ph, int op);
    if (ph == 0) return "R3";
    if (ph == 1) return "R5";
    if (ph == 3) return "R10";
    if (op <= 2) return "R6";
    if (op == 3) return "R7";
    return "R8";
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: compare outputs against the model, then advance the model
  task automatic tick(string prev_tag);
    logic [17:0] ew;
    bit last;
    int nph;
    #1;
    ew = ref_word(m_ph, m_st, op_i, zero_i);
    check(req_of(m_ph, op_i), "ctrl", ctrl_o, ew);
    check("R11", "ctrl rest", ctrl_o & ~ew, 0);
    check(prev_tag, "icc", icc_o, m_ph);
    check("R2", "step", step_o, m_st);
    check("R9", "ie", ie_o, m_ie);
    check("R10", "save addr", save_addr_o, (m_ph == 3 && m_st == 2) ? SAVE : 0);
    check("R10", "isr addr", isr_addr_o, (m_ph == 3 && m_st == 2) ? ISR : 0);
    last = (m_st >= len_of(m_ph, op_i));
    nph = m_ph;
    if (last) begin
      case (m_ph)
        0: nph = ind_i ? 1 : 2;
        1: nph = 2;
        2: nph = (irq_i && m_ie) ? 3 : 0;
        default: nph = 0;
      endcase
    end
    if (m_ph == 2 && last && irq_i && m_ie) m_ie = 0;
    else if (m_ph == 2 && op_i == 6 && m_st == 1) m_ie = 1;
    @(posedge clk);
    m_st = last ? 1 : m_st + 1;
    m_ph = nph;
    @(negedge clk);
  endtask

  // run one full instruction from fetch step 1 back to fetch step 1
  task automatic run_instr(int op, bit ind, bit irq, bit z);
    string tag;
    op_i = 3'(op); ind_i = ind; irq_i = irq; zero_i = z;
    tag = "R2";
    do begin
      int p = m_ph;
      tick(tag);
      tag = (p == 0) ? "R4" : (p == 2) ? "R9" : "R2";
    end while (!(m_ph == 0 && m_st == 1) && cycles < WATCHDOG);
    // confirm the new phase code after the return
    #1; check(tag, "icc return", icc_o, m_ph);
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_ph = 0; m_st = 1; m_ie = 0;
    #1;
    check("R1", "reset icc", icc_o, 0);
    check("R1", "reset step", step_o, 1);
    check("R1", "reset ie", ie_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R3 R4 R6: direct add, then indirect add
    run_instr(0, 0, 0, 0);
    run_instr(0, 1, 0, 0);
    // R6 and/load, R7 store
    run_instr(1, 0, 0, 0);
    run_instr(2, 1, 0, 0);
    run_instr(3, 0, 0, 0);
    run_instr(3, 1, 0, 0);
    // R8 jumps with both flag values, nop
    run_instr(4, 0, 0, 0);
    run_instr(5, 0, 0, 1);
    run_instr(5, 0, 0, 0);
    run_instr(7, 0, 1, 0);   // R9: request ignored while enable is off
    check("R9", "no intr when disabled", ie_o, 0);
    // R9 collision: enable set, then set again with request pending
    run_instr(6, 0, 0, 0);
    check("R8", "ie after EI", ie_o, 1);
    run_instr(6, 0, 1, 0);   // clear beats set, interrupt phase runs (R10)
    check("R9", "ie after collision", ie_o, 0);
    run_instr(6, 0, 0, 0);
    run_instr(0, 1, 1, 0);   // R9 R10 interrupt after an indirect add
    // R1: reset in mid-flight clears the enable
    run_instr(6, 0, 0, 0);
    op_i = 3'd0;
    tick("R2"); tick("R2");
    do_reset();
    // random instruction streams
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom;
      run_instr(r & 7, (r >> 3) & 1, ((r >> 4) & 3) == 0, (r >> 6) & 1);
    end
    finish_run();
  end

endmodule